// File: doc/BRIEF.md
# Chip Erase Command Decoder with Embedded Erase

This block is the device-side command front end of a small on-chip memory array that behaves like a NOR flash. It watches host bus writes for a fixed six-write chip erase sequence. When the last write of that sequence is accepted, it runs an internal erase on its own. First it writes zero to every word of the array and checks each word. Then it sets every word to the erased value, all ones. The host needs no zero-fill pass of its own.

While the erase is running, host reads do not return array data. They return a status word in which bit 7 is held low and bits 6 and 2 flip on every read, so the host can poll for completion. Host writes are ignored while the erase runs. A hardware reset stops the erase at once and puts the block back in read mode. Words already handled keep their new value and the rest keep their old value. When the erase completes, the block returns to read mode with the command decoder back at its first step.

Top module: `nor_erase_top`

## Requirements
- R1: While `rstN` is low and after it is released, `rdData` is 0x0000 and the decoder waits for the first write of the sequence.
- R2: An erase starts only after six accepted writes, in this order (address/data): 0x555/0x00AA, 0x2AA/0x0055, 0x555/0x0080, 0x555/0x00AA, 0x2AA/0x0055, 0x555/0x0010. The erase starts on the clock edge that samples the sixth write.
- R3: A write that does not match the expected step returns the decoder to its first step. A later complete and correct sequence still starts an erase.
- R4: On the 256 clock edges after the sixth write, words 0 to 255 are written to 0x0000, one word per edge in ascending order. The next 256 edges verify those words, one word per edge. No word is set to the erased value before every word has been zero-filled.
- R5: On the next 256 edges, words 0 to 255 are written to 0xFFFF, one word per edge in ascending order. A read sampled on the 768th edge after the sixth write returns status. A read sampled on the 769th edge returns array data.
- R6: While an erase runs, a read returns a status word with bit 7 = 0, bit 6 equal to bit 2, and all other bits 0. The first status read after the erase starts gives 0x0000, and each further status read inverts bits 6 and 2 (0x0044, then 0x0000, and so on).
- R7: Writes made while an erase runs are ignored. They do not advance the decoder, so a partial sequence written during the erase leaves nothing behind after it ends.
- R8: Pulling `rstN` low during an erase stops it at once. Words written before the reset keep their new value, the other words are unchanged, and the block then reads array data.
- R9: In read mode, a read returns the array word selected by `addr[7:0]` on the cycle after the edge that samples `rdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous; aborts an erase |
| wrEn | input | 1 | Host write strobe, sampled on the rising edge |
| rdEn | input | 1 | Host read strobe, sampled on the rising edge |
| addr | input | 12 | Host word address |
| wrData | input | 16 | Host write data |
| rdData | output | 16 | Registered read data or status word |

## Verification
The decoder is driven with the exact six-write sequence, with a sequence that has a wrong data value in its fifth write, and with a sequence broken by a repeated first write and then restarted. These separate exact matching from matching that is too loose, and they show that recovery after a mismatch works.

Erases are cut short by reset in three places: partway through the zero-fill, during the verify pass and partway through the erase pass. The word just below each cut point and the word at the cut point are then read back. This confirms the ascending one-word-per-edge order and shows that zero-fill comes before erase.

One full erase is polled with status reads at the start and at the exact completion edge, which checks the toggle pattern and the 768-cycle length. A second full erase has five command writes issued while it runs. A single final command write after it completes then shows whether any decoder state leaked through.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PREPROG = 2'd1,
    ST_VERIFY  = 2'd2,
    ST_ERASE   = 2'd3
  } opState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrZero;     // write 0 to the word at idx
    logic wrOnes;     // write all ones to the word at idx
    logic opActive;   // erase running: reads return status
    logic clrToggle;  // erase starting: clear the toggle bit
  } dpCtl_t;

  localparam int CMD_LEN = 6;

  function automatic logic [11:0] expAddr(input logic [2:0] step);
    case (step)
      3'd1, 3'd4: expAddr = 12'h2AA;
      default:    expAddr = 12'h555;
    endcase
  endfunction

  function automatic logic [7:0] expData(input logic [2:0] step);
    case (step)
      3'd0, 3'd3: expData = 8'hAA;
      3'd1, 3'd4: expData = 8'h55;
      3'd2:       expData = 8'h80;
      default:    expData = 8'h10;
    endcase
  endfunction

endpackage

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl
  import nor_erase_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              verifyOk,
  output dpCtl_t            ctl,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [2:0]       LAST_STEP = 3'(CMD_LEN - 1);

  opState_t         state;
  logic [2:0]       step;
  logic [IDX_W-1:0] ptr;
  logic             cmdMatch;
  logic             seqDone;

  assign cmdMatch = (addr == ADDR_W'(expAddr(step))) &&
                    (wrData == DATA_W'(expData(step)));
  assign seqDone  = (state == ST_IDLE) && wrEn && cmdMatch && (step == LAST_STEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= '0;
      ptr   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wrEn) begin
            if (!cmdMatch) begin
              step <= '0;
            end else if (step == LAST_STEP) begin
              step  <= '0;
              ptr   <= '0;
              state <= ST_PREPROG;
            end else begin
              step <= step + 3'd1;
            end
          end
        end
        ST_PREPROG: begin
          if (ptr == LAST_IDX) begin
            ptr   <= '0;
            state <= ST_VERIFY;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        ST_VERIFY: begin
          if (!verifyOk) begin
            state <= ST_PREPROG;   // rewrite the failing word and continue
          end else if (ptr == LAST_IDX) begin
            ptr   <= '0;
            state <= ST_ERASE;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        default: begin
          if (ptr == LAST_IDX) begin
            ptr   <= '0;
            step  <= '0;
            state <= ST_IDLE;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl.wrZero    = (state == ST_PREPROG);
    ctl.wrOnes    = (state == ST_ERASE);
    ctl.opActive  = (state != ST_IDLE);
    ctl.clrToggle = seqDone;
    idx           = ptr;
  end

  // R2: the zero-fill phase is entered only from a completed sequence
  a_r2_start_after_full_seq: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PREPROG && $past(state) == ST_IDLE) |-> ($past(step) == LAST_STEP && $past(wrEn)));

  // R4: verify is reached only from the zero-fill phase
  a_r4_verify_after_preprog: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VERIFY && $past(state) != ST_VERIFY) |-> ($past(state) == ST_PREPROG));

  // R4: the erase pass starts only after verify has finished
  a_r4_erase_after_verify: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && $past(state) != ST_ERASE) |-> ($past(state) == ST_VERIFY));

  // R5: the erase pass walks one word per edge
  a_r5_erase_walk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && $past(state) == ST_ERASE) |-> (ptr == IDX_W'($past(ptr) + 1'b1)));

  // R7: the last erase word returns to read mode with a fresh decoder
  a_r7_done_clean: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && ptr == LAST_IDX) |=> (state == ST_IDLE && step == 3'd0));

endmodule

// File: rtl/nor_array_dp.sv
module nor_array_dp
  import nor_erase_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [IDX_W-1:0]  idx,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              verifyOk,
  output logic [DATA_W-1:0] rdData
);

  localparam int POLL_BIT = 7;
  localparam int TGL_HI   = 6;
  localparam int TGL_LO   = 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              toggle;
  logic [DATA_W-1:0] statusWord;

  // array contents survive reset, like a nonvolatile store
  always_ff @(posedge clk) begin
    if (ctl.wrZero) begin
      mem[idx] <= '0;
    end else if (ctl.wrOnes) begin
      mem[idx] <= '1;
    end
  end

  assign verifyOk = (mem[idx] == '0);

  always_comb begin
    statusWord           = '0;
    statusWord[POLL_BIT] = 1'b0;
    statusWord[TGL_HI]   = toggle;
    statusWord[TGL_LO]   = toggle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      toggle <= 1'b0;
    end else begin
      if (rdEn) begin
        rdData <= ctl.opActive ? statusWord : mem[rdIdx];
      end
      if (ctl.clrToggle) begin
        toggle <= 1'b0;
      end else if (rdEn && ctl.opActive) begin
        toggle <= ~toggle;
      end
    end
  end

  // R6: status words keep bit 7 low and bits 6 and 2 in step
  a_r6_status_format: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.opActive && rdEn) |=> (rdData[POLL_BIT] == 1'b0 && rdData[TGL_HI] == rdData[TGL_LO]));

  // R6: back-to-back status reads alternate the toggle bits
  a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.opActive && rdEn && $past(ctl.opActive && rdEn)) |=> (rdData[TGL_HI] != $past(rdData[TGL_HI])));

endmodule

// File: rtl/nor_erase_top.sv
module nor_erase_top
  import nor_erase_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int IDX_W = $clog2(DEPTH);

  dpCtl_t           ctl;
  logic [IDX_W-1:0] idx;
  logic             verifyOk;

  nor_erase_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .verifyOk(verifyOk), .ctl(ctl), .idx(idx)
  );

  nor_array_dp #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idx(idx), .rdEn(rdEn),
    .rdIdx(addr[IDX_W-1:0]), .verifyOk(verifyOk), .rdData(rdData)
  );

endmodule

// File: tb/nor_erase_top_bench.sv
module nor_erase_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;
  logic        tgl = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  nor_erase_top u_nor_erase_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each returned read against the scoreboard
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  // all tasks start and end on a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [15:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic statusRead(input string tag);
    busRead(12'h000, tgl ? 16'h0044 : 16'h0000, tag);
    tgl = ~tgl;
  endtask

  task automatic sendErase();
    busWrite(12'h555, 16'h00AA);
    busWrite(12'h2AA, 16'h0055);
    busWrite(12'h555, 16'h0080);
    busWrite(12'h555, 16'h00AA);
    busWrite(12'h2AA, 16'h0055);
    busWrite(12'h555, 16'h0010);
    tgl = 1'b0;
  endtask

  task automatic pulseReset();
    rstN = 1'b0;
    idle(1);
    rstN = 1'b1;
    tgl = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    idle(2);
    check("R1 rdData in reset", rdData, 16'h0000);
    rstN = 1'b1;
    idle(1);
    check("R1 rdData after reset", rdData, 16'h0000);

    // full erase with polling; sixth write sampled at E0
    sendErase();
    statusRead("R6 first status");          // E1
    statusRead("R6 second status");         // E2
    statusRead("R6 third status");          // E3
    idle(764);
    statusRead("R5 status on edge 768");    // E768
    busRead(12'h000, 16'hFFFF, "R5 data on edge 769");
    busRead(12'h080, 16'hFFFF, "R9 word 128 erased");
    busRead(12'hAFF, 16'hFFFF, "R9 word 255 via low address bits");

    // abort during zero-fill after 100 words
    sendErase();
    idle(100);
    pulseReset();
    busRead(12'h000, 16'h0000, "R8 word 0 zero-filled");
    busRead(12'h063, 16'h0000, "R4 word 99 zero-filled");
    busRead(12'h064, 16'hFFFF, "R8 word 100 untouched");
    busRead(12'h0FF, 16'hFFFF, "R8 word 255 untouched");

    // abort during erase pass after 50 words
    sendErase();
    idle(512 + 50);
    pulseReset();
    busRead(12'h031, 16'hFFFF, "R5 word 49 erased");
    busRead(12'h032, 16'h0000, "R4 word 50 zero before erase");
    busRead(12'h0FF, 16'h0000, "R4 word 255 zero before erase");

    // full erase with a partial sequence written while busy
    sendErase();
    busWrite(12'h555, 16'h00AA);
    busWrite(12'h2AA, 16'h0055);
    busWrite(12'h555, 16'h0080);
    busWrite(12'h555, 16'h00AA);
    busWrite(12'h2AA, 16'h0055);
    idle(763);
    busWrite(12'h555, 16'h0010);
    busRead(12'h03C, 16'hFFFF, "R7 no restart from busy writes");
    busRead(12'h0FF, 16'hFFFF, "R5 word 255 after full erase");

    // sequence with wrong fifth data
    busWrite(12'h555, 16'h00AA);
    busWrite(12'h2AA, 16'h0055);
    busWrite(12'h555, 16'h0080);
    busWrite(12'h555, 16'h00AA);
    busWrite(12'h2AA, 16'h0054);
    busWrite(12'h555, 16'h0010);
    busRead(12'h003, 16'hFFFF, "R2 wrong data starts nothing");

    // broken sequence, then a clean one
    busWrite(12'h555, 16'h00AA);
    busWrite(12'h2AA, 16'h0055);
    busWrite(12'h555, 16'h00AA);
    busRead(12'h004, 16'hFFFF, "R3 mismatch starts nothing");
    sendErase();
    statusRead("R3 clean sequence after mismatch");   // E1
    idle(265);                                         // abort in verify
    pulseReset();
    busRead(12'h0FF, 16'h0000, "R4 all words zero during verify");
    busRead(12'h000, 16'h0000, "R4 word 0 zero during verify");
    busRead(12'h07F, 16'h0000, "R8 read mode after verify abort");

    idle(3);
    summary();
  end

endmodule